// File: doc/BRIEF.md
# Processor Status Flag Unit

This block holds the status byte of a small 8-bit accumulator processor. Each cycle, the datapath reports the class of operation it has just finished, together with its operands, its result, the adder carry-out and the bit that a shift or rotate pushed out. From these the unit updates the sign, zero, carry and overflow flags. Single-cycle strobes from the sequencer set or clear carry, decimal and interrupt-mask, and clear overflow.

The unit serves the stack in both directions. It presents the live register, and it presents a separate byte image to write when the register is pushed. In that image bit 4 marks whether the push came from software (a break or an explicit push) or from a hardware interrupt entry. A pulled byte restores the stored flags. Bit 5 and bit 4 of the pulled byte are discarded.

The unit also decides whether a pending interrupt is accepted. The mask flag holds off the maskable request but never the non-maskable one. The decimal flag is kept as plain state and changes no flag result.

Top module: `psr_unit`

## Requirements
- R1: After reset the live status reads 0x24: mask flag set, bit 5 set, every other bit clear.
- R2: Status bits are, from bit 7 down to bit 0: N, V, always-1, 0, D, I, Z, C. The op_class codes are 0 none, 1 add, 2 subtract, 3 compare, 4 shift/rotate, 5 logical, 6 load. For codes 1 to 6 with op_valid high, N takes bit 7 of res and Z is set exactly when res is zero. Code 0 changes nothing.
- R3: An add sets V when both operands have the same sign and the sign of res differs from it. A subtract sets V when the operands' signs differ and the sign of res differs from opa. Compare leaves V unchanged. A clr_v strobe forces V to 0, and it overrides the operation.
- R4: C takes carry_out on an add and on a subtract, where carry_out is the ALU's no-borrow flag. On a compare, C is 1 exactly when opa >= opb as unsigned values, and carry_out is ignored.
- R5: On a shift or rotate, C takes shift_out.
- R6: Logical and load operations leave C and V unchanged.
- R7: The set_c/clr_c, set_d/clr_d and set_i/clr_i strobes force their flag. When a set and a clear of the same flag arrive together, the set wins. A strobe overrides the operation's result for the same flag.
- R8: The D flag does not change how N, Z, C and V are computed.
- R9: In the live status, bit 5 is always 1 and bit 4 is always 0.
- R10: push_image equals the live status except that bit 4 equals push_src. push_src is 1 for a break or register push and 0 for a hardware interrupt entry.
- R11: pull_en loads N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 of pull_data and ignores bits 5 and 4. A pull takes priority over any operation or strobe in the same cycle.
- R12: irq_entry sets I. int_take is high when nmi_req is high, or when irq_req is high and I is clear. Clearing I therefore lets a waiting irq_req through in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A completed ALU or shifter operation is presented |
| op_class | input | 3 | Operation class code |
| opa | input | 8 | First operand (minuend for subtract and compare) |
| opb | input | 8 | Second operand |
| res | input | 8 | Operation result |
| carry_out | input | 1 | Adder carry-out, or no-borrow on subtract |
| shift_out | input | 1 | Bit shifted out by a shift or rotate |
| set_c | input | 1 | Set carry |
| clr_c | input | 1 | Clear carry |
| set_d | input | 1 | Set decimal flag |
| clr_d | input | 1 | Clear decimal flag |
| set_i | input | 1 | Set interrupt mask |
| clr_i | input | 1 | Clear interrupt mask |
| clr_v | input | 1 | Clear overflow |
| irq_entry | input | 1 | Interrupt entry, sets the mask |
| pull_en | input | 1 | Restore status from pull_data |
| pull_data | input | 8 | Byte pulled from the stack |
| push_src | input | 1 | 1 = software push/break, 0 = hardware entry |
| irq_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| status | output | 8 | Live status register |
| push_image | output | 8 | Byte to write when pushing status |
| int_take | output | 1 | Interrupt accepted |

## Verification
The bench targets compare with a carry_out that contradicts the operands; a design that reused the adder carry would flag the wrong ordering. It runs a logical and a load after flags are set, which catches a design that clobbers C or V. It sends set and clear strobes together with a conflicting operation, where a wrong priority leaves the carry or overflow wrong. An all-ones pulled byte would leak bit 4 into the live register, or drop bit 5 on an all-zeros pull, if the design did not mask them. Clearing the mask while a maskable request waits must make int_take rise, and a design that kept a registered mask copy would hold it low.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int STAT_W = 8;

  // bit positions inside the status byte; stack images depend on them
  localparam int BIT_N  = 7;
  localparam int BIT_V  = 6;
  localparam int BIT_ONE = 5;
  localparam int BIT_SRC = 4;
  localparam int BIT_D  = 3;
  localparam int BIT_I  = 2;
  localparam int BIT_Z  = 1;
  localparam int BIT_C  = 0;

  typedef enum logic [2:0] {
    OPC_NONE  = 3'd0,
    OPC_ADD   = 3'd1,
    OPC_SUB   = 3'd2,
    OPC_CMP   = 3'd3,
    OPC_SHIFT = 3'd4,
    OPC_LOGIC = 3'd5,
    OPC_LOAD  = 3'd6
  } op_class_e;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  localparam flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/psr_flag_calc.sv
module psr_flag_calc
  import psr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          op_valid,
  input  logic [2:0]    op_class,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] res,
  input  logic          carry_out,
  input  logic          shift_out,
  output logic          upd_nz,
  output logic          upd_c,
  output logic          upd_v,
  output logic          n_new,
  output logic          z_new,
  output logic          c_new,
  output logic          v_new
);

  localparam int MSB = DW - 1;

  op_class_e cls;
  logic      sa, sb, sr;
  logic      ovf_add, ovf_sub;
  logic      no_borrow_cmp;

  always_comb begin
    cls           = op_class_e'(op_class);
    sa            = opa[MSB];
    sb            = opb[MSB];
    sr            = res[MSB];
    ovf_add       = (sa == sb) && (sr != sa);
    ovf_sub       = (sa != sb) && (sr != sa);
    no_borrow_cmp = (opa >= opb);
  end

  always_comb begin
    upd_nz = 1'b0;
    upd_c  = 1'b0;
    upd_v  = 1'b0;
    c_new  = 1'b0;
    v_new  = 1'b0;
    n_new  = sr;
    z_new  = (res == '0);
    if (op_valid) begin
      unique case (cls)
        OPC_ADD: begin
          upd_nz = 1'b1;
          upd_c  = 1'b1;
          upd_v  = 1'b1;
          c_new  = carry_out;
          v_new  = ovf_add;
        end
        OPC_SUB: begin
          upd_nz = 1'b1;
          upd_c  = 1'b1;
          upd_v  = 1'b1;
          c_new  = carry_out;
          v_new  = ovf_sub;
        end
        OPC_CMP: begin
          upd_nz = 1'b1;
          upd_c  = 1'b1;
          c_new  = no_borrow_cmp;
        end
        OPC_SHIFT: begin
          upd_nz = 1'b1;
          upd_c  = 1'b1;
          c_new  = shift_out;
        end
        OPC_LOGIC, OPC_LOAD: begin
          upd_nz = 1'b1;
        end
        default: begin
          upd_nz = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/psr_flag_regs.sv
module psr_flag_regs
  import psr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_nz,
  input  logic               upd_c,
  input  logic               upd_v,
  input  logic               n_new,
  input  logic               z_new,
  input  logic               c_new,
  input  logic               v_new,
  input  logic               set_c,
  input  logic               clr_c,
  input  logic               set_d,
  input  logic               clr_d,
  input  logic               set_i,
  input  logic               clr_i,
  input  logic               clr_v,
  input  logic               irq_entry,
  input  logic               pull_en,
  input  logic [STAT_W-1:0]  pull_data,
  output flags_t             flags_q
);

  flags_t flags_d;
  logic   flags_en;

  always_comb begin
    flags_en = pull_en | upd_nz | upd_c | upd_v |
               set_c | clr_c | set_d | clr_d |
               set_i | clr_i | clr_v | irq_entry;
  end

  always_comb begin
    flags_d = flags_q;
    if (pull_en) begin
      flags_d.n = pull_data[BIT_N];
      flags_d.v = pull_data[BIT_V];
      flags_d.d = pull_data[BIT_D];
      flags_d.i = pull_data[BIT_I];
      flags_d.z = pull_data[BIT_Z];
      flags_d.c = pull_data[BIT_C];
    end else begin
      if (upd_nz) begin
        flags_d.n = n_new;
        flags_d.z = z_new;
      end
      if (upd_c) begin
        flags_d.c = c_new;
      end
      if (upd_v) begin
        flags_d.v = v_new;
      end
      if (clr_c) flags_d.c = 1'b0;
      if (set_c) flags_d.c = 1'b1;
      if (clr_v) flags_d.v = 1'b0;
      if (clr_d) flags_d.d = 1'b0;
      if (set_d) flags_d.d = 1'b1;
      if (clr_i) flags_d.i = 1'b0;
      if (set_i || irq_entry) flags_d.i = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= FLAGS_RESET;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  // R3: an overflow clear is honoured in the following cycle
  a_r3_clr_v_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_v && !pull_en) |=> !flags_q.v);

  // R12: interrupt entry leaves the mask set
  a_r12_entry_sets_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_entry && !pull_en) |=> flags_q.i);

  // R6: logical and load results never move carry or overflow
  a_r6_keep_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_c && !upd_v && !pull_en && !set_c && !clr_c && !clr_v)
      |=> ($stable(flags_q.c) && $stable(flags_q.v)));

  // R11: a pull restores the six stored flags from the pulled byte
  a_r11_pull_restores: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en |=> (flags_q.n == $past(pull_data[BIT_N]) &&
                 flags_q.v == $past(pull_data[BIT_V]) &&
                 flags_q.d == $past(pull_data[BIT_D]) &&
                 flags_q.i == $past(pull_data[BIT_I]) &&
                 flags_q.z == $past(pull_data[BIT_Z]) &&
                 flags_q.c == $past(pull_data[BIT_C])));

  // R7: a carry set strobe wins over clear strobe and operation
  a_r7_set_c_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_c && !pull_en) |=> flags_q.c);

endmodule

// File: rtl/psr_push_fmt.sv
module psr_push_fmt
  import psr_pkg::*;
(
  input  flags_t              flags,
  input  logic                push_src,
  output logic [STAT_W-1:0]   status,
  output logic [STAT_W-1:0]   push_image
);

  logic [STAT_W-1:0] base;

  always_comb begin
    base          = '0;
    base[BIT_N]   = flags.n;
    base[BIT_V]   = flags.v;
    base[BIT_ONE] = 1'b1;
    base[BIT_SRC] = 1'b0;
    base[BIT_D]   = flags.d;
    base[BIT_I]   = flags.i;
    base[BIT_Z]   = flags.z;
    base[BIT_C]   = flags.c;
  end

  always_comb begin
    status             = base;
    push_image         = base;
    push_image[BIT_SRC] = push_src;
  end

endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_class,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [DW-1:0] res,
  input  logic          carry_out,
  input  logic          shift_out,
  input  logic          set_c,
  input  logic          clr_c,
  input  logic          set_d,
  input  logic          clr_d,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic          clr_v,
  input  logic          irq_entry,
  input  logic          pull_en,
  input  logic [7:0]    pull_data,
  input  logic          push_src,
  input  logic          irq_req,
  input  logic          nmi_req,
  output logic [7:0]    status,
  output logic [7:0]    push_image,
  output logic          int_take
);

  logic   rst_n_sync;
  logic   upd_nz, upd_c, upd_v;
  logic   n_new, z_new, c_new, v_new;
  flags_t flags_q;

  psr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  psr_flag_calc #(.DW(DW)) u_calc (
    .op_valid  (op_valid),
    .op_class  (op_class),
    .opa       (opa),
    .opb       (opb),
    .res       (res),
    .carry_out (carry_out),
    .shift_out (shift_out),
    .upd_nz    (upd_nz),
    .upd_c     (upd_c),
    .upd_v     (upd_v),
    .n_new     (n_new),
    .z_new     (z_new),
    .c_new     (c_new),
    .v_new     (v_new)
  );

  psr_flag_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .upd_nz    (upd_nz),
    .upd_c     (upd_c),
    .upd_v     (upd_v),
    .n_new     (n_new),
    .z_new     (z_new),
    .c_new     (c_new),
    .v_new     (v_new),
    .set_c     (set_c),
    .clr_c     (clr_c),
    .set_d     (set_d),
    .clr_d     (clr_d),
    .set_i     (set_i),
    .clr_i     (clr_i),
    .clr_v     (clr_v),
    .irq_entry (irq_entry),
    .pull_en   (pull_en),
    .pull_data (pull_data),
    .flags_q   (flags_q)
  );

  psr_push_fmt u_fmt (
    .flags      (flags_q),
    .push_src   (push_src),
    .status     (status),
    .push_image (push_image)
  );

  always_comb begin
    int_take = nmi_req | (irq_req & ~status[BIT_I]);
  end

  // R12: a masked maskable request alone is never accepted
  a_r12_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (irq_req && !nmi_req && status[BIT_I]) |-> !int_take);

  // R12: a non-maskable request is always accepted
  a_r12_nmi_passes: assert property (@(posedge clk) disable iff (!rst_n_sync)
    nmi_req |-> int_take);

  // R10: push image differs from live status only in bit 4
  a_r10_push_image: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (push_image[BIT_SRC] == push_src) &&
    ({push_image[7:5], push_image[3:0]} == {status[7:5], status[3:0]}));

  // R9: live status keeps bit 5 high and bit 4 low
  a_r9_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n_sync)
    status[BIT_ONE] && !status[BIT_SRC]);

endmodule

// File: tb/tb_psr_unit.sv
module tb_psr_unit;

  logic       clk;
  logic       rst_n;
  logic       op_valid;
  logic [2:0] op_class;
  logic [7:0] opa, opb, res;
  logic       carry_out, shift_out;
  logic       set_c, clr_c, set_d, clr_d, set_i, clr_i, clr_v;
  logic       irq_entry, pull_en;
  logic [7:0] pull_data;
  logic       push_src, irq_req, nmi_req;
  logic [7:0] status, push_image;
  logic       int_take;

  int n_checks;
  int n_fail;
  bit done;

  psr_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .opa(opa), .opb(opb), .res(res), .carry_out(carry_out), .shift_out(shift_out),
    .set_c(set_c), .clr_c(clr_c), .set_d(set_d), .clr_d(clr_d),
    .set_i(set_i), .clr_i(clr_i), .clr_v(clr_v), .irq_entry(irq_entry),
    .pull_en(pull_en), .pull_data(pull_data), .push_src(push_src),
    .irq_req(irq_req), .nmi_req(nmi_req), .status(status),
    .push_image(push_image), .int_take(int_take)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {op class, opa, opb, res, {2'b0, carry_out, shift_out}, expected status}
  localparam logic [39:0] VEC [12] = '{
    40'h1_50_50_A0_0_E4,  // R2 R3 add signed overflow
    40'h1_FF_01_00_2_27,  // R4 add carry, Z
    40'h5_00_00_80_0_A5,  // R6 logical keeps C
    40'h2_80_01_7F_2_65,  // R3 subtract overflow
    40'h6_00_00_00_0_67,  // R6 load keeps C V
    40'h3_10_20_F0_2_E4,  // R4 compare less, carry_out ignored
    40'h3_20_20_00_0_67,  // R4 compare equal
    40'h4_00_00_00_0_66,  // R5 shift out 0
    40'h4_00_00_FE_1_E5,  // R5 shift out 1
    40'h2_05_03_02_2_25,  // R4 subtract no borrow
    40'h2_03_05_FE_0_A4,  // R4 subtract borrow
    40'h0_00_00_00_0_A4   // R2 no operation
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    op_valid = 0; op_class = 0; opa = 0; opb = 0; res = 0;
    carry_out = 0; shift_out = 0;
    set_c = 0; clr_c = 0; set_d = 0; clr_d = 0; set_i = 0; clr_i = 0; clr_v = 0;
    irq_entry = 0; pull_en = 0; pull_data = 0;
  endtask

  // inputs set up by caller after negedge; commits one edge and samples after it
  task automatic commit();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; done = 0;
    idle();
    push_src = 1; irq_req = 0; nmi_req = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(posedge clk);
    #1;

    // R1 reset state, R10 push image both sources, R12 masking
    chk("R1 reset status", status, 8'h24);
    push_src = 1; #1;
    chk("R10 push image software", push_image, 8'h34);
    push_src = 0; #1;
    chk("R10 push image hardware", push_image, 8'h24);
    irq_req = 1; #1;
    chk("R12 masked irq", {7'b0, int_take}, 8'h00);
    nmi_req = 1; #1;
    chk("R12 nmi ignores mask", {7'b0, int_take}, 8'h01);
    nmi_req = 0; irq_req = 0;

    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      idle();
      op_valid  = 1;
      op_class  = VEC[k][38:36];
      opa       = VEC[k][35:28];
      opb       = VEC[k][27:20];
      res       = VEC[k][19:12];
      carry_out = VEC[k][9];
      shift_out = VEC[k][8];
      commit();
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d", k), status, VEC[k][7:0]);
      chk("R9 live bits 5/4", {6'b0, status[5:4]}, 8'h02);
    end

    // R12 clearing the mask releases a waiting request
    @(negedge clk); idle(); irq_req = 1; clr_i = 1;
    commit();
    chk("R7 clr_i", status, 8'hA0);
    chk("R12 irq after unmask", {7'b0, int_take}, 8'h01);
    @(negedge clk); idle(); irq_entry = 1;
    commit();
    chk("R12 entry sets I", status, 8'hA4);
    chk("R12 entry blocks irq", {7'b0, int_take}, 8'h00);
    irq_req = 0;

    // R7 set beats clear beats operation
    @(negedge clk); idle();
    op_valid = 1; op_class = 3'd1; res = 8'h01; carry_out = 0;
    set_c = 1; clr_c = 1;
    commit();
    chk("R7 set_c wins", status, 8'h25);

    // R3 clr_v overrides add overflow
    @(negedge clk); idle();
    op_valid = 1; op_class = 3'd1; opa = 8'h50; opb = 8'h50; res = 8'hA0;
    clr_v = 1;
    commit();
    chk("R3 clr_v over add", status, 8'hA4);

    // R7 R8 decimal flag stored, arithmetic untouched
    @(negedge clk); idle(); set_d = 1; clr_d = 1;
    commit();
    chk("R7 set_d wins", status, 8'hAC);
    @(negedge clk); idle();
    op_valid = 1; op_class = 3'd1; opa = 8'h09; opb = 8'h01; res = 8'h0A;
    commit();
    chk("R8 add in decimal mode", status, 8'h2C);
    @(negedge clk); idle(); clr_d = 1;
    commit();
    chk("R7 clr_d", status, 8'h24);
    @(negedge clk); idle(); clr_c = 1; set_i = 1;
    commit();
    chk("R7 set_i kept, clr_c", status, 8'h24);

    // R11 pull ignores bits 5/4 and beats an operation
    @(negedge clk); idle();
    pull_en = 1; pull_data = 8'hFF;
    op_valid = 1; op_class = 3'd6; res = 8'h00; clr_c = 1;
    commit();
    chk("R11 pull all ones", status, 8'hEF);
    push_src = 1; #1;
    chk("R10 push after pull sw", push_image, 8'hFF);
    push_src = 0; #1;
    chk("R10 push after pull hw", push_image, 8'hEF);
    @(negedge clk); idle(); pull_en = 1; pull_data = 8'h00;
    commit();
    chk("R11 pull zeros keeps bit5", status, 8'h20);
    @(negedge clk); idle(); pull_en = 1; pull_data = 8'h30;
    commit();
    chk("R11 R9 pulled 5/4 ignored", status, 8'h20);

    @(negedge clk); idle();
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule